// File: doc/BRIEF.md
# Shared Address/Data External SRAM Bus Controller

This block connects an internal 8-bit processor to a 64K x 8 asynchronous SRAM. The processor raises a one-cycle start strobe together with a 16-bit address, write data and a write flag. The block runs one external access and returns a one-cycle done pulse. On a read, the byte from memory appears with that pulse. A configuration bit is sampled when a request is accepted and chooses between two pin layouts. In shared-bus operation the low address byte and the data travel on the same eight pins, and an address-latch strobe controls an external transparent latch. In split-bus operation the low address has its own output and the latch strobe stays low.

An access runs through fixed phases: latch strobe (shared mode only), a one-cycle address hold, setup, strobe and recovery. Three programmable counts set the length in clock cycles of the latch-strobe phase, the setup phase and the strobe phase. The upper address byte has its own pins in both modes. The SRAM chip enable may be tied active. Active-low read and write strobes drive the memory's output and write enables.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: `cfg_mux` is sampled on the cycle a request is accepted: 1 selects shared-bus mode and 0 selects split-bus mode for that whole access.
- R2: In shared mode `ext_ale` is high for exactly `cfg_ale_cyc` cycles, starting the cycle after acceptance. During that time `ext_ad_oe` is 1 and `ext_ad_out` equals address bits [7:0]. `ext_addr_hi` equals address bits [15:8] for the whole access.
- R3: In shared mode, in the one cycle after `ext_ale` falls, the address stays driven and unchanged on `ext_ad_out`, and both strobes stay high.
- R4: The setup phase lasts `cfg_setup_cyc` cycles with both strobes high. On a write `ext_ad_out` carries the write data with `ext_ad_oe`=1. On a read `ext_ad_oe` is 0 from setup through the end of the access.
- R5: The strobe phase lasts `cfg_strobe_cyc` cycles. `ext_rd_n` is low for a read and `ext_wr_n` is low for a write. The two are never low together, and both are high whenever `ext_ale` is high.
- R6: On a write the data stays driven for one cycle after `ext_wr_n` returns high.
- R7: Read data is sampled on the clock edge that ends the last strobe cycle. It is shown on `rsp_rdata` with the done pulse and held until the next read completes (reset value 0).
- R8: `rsp_done` is high for exactly one cycle, the first cycle after the strobe ends.
- R9: In split mode `ext_ale` stays 0, `ext_addr_lo` equals address bits [7:0] for the access, and `ext_ad_oe` is high only for write data. In shared mode `ext_addr_lo` is 0.
- R10: `req_start` is ignored in every cycle in which the controller is not idle, including the done cycle.
- R11: A programmed count of 0 behaves as a count of 1.
- R12: After reset `ext_ale`=0, `ext_rd_n`=`ext_wr_n`=1, `ext_ad_oe`=0, `rsp_done`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux | input | 1 | 1 = shared address/data bus, 0 = split bus |
| cfg_ale_cyc | input | 4 | Latch-strobe phase length in cycles |
| cfg_setup_cyc | input | 4 | Setup phase length in cycles |
| cfg_strobe_cyc | input | 4 | Read/write strobe width in cycles |
| req_start | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| ext_ad_out | output | 8 | Shared pins, driven value |
| ext_ad_oe | output | 1 | Output enable for the shared pins |
| ext_ad_in | input | 8 | Shared pins, sampled value |
| ext_addr_hi | output | 8 | Upper address byte |
| ext_addr_lo | output | 8 | Low address byte (split mode) |
| ext_ale | output | 1 | Address latch strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
The embedded properties watch several rules on every cycle. The two strobes are never low together, and both stay high while the latch strobe is high. The address is held across the falling latch strobe, the pins are released during a read strobe, and write data outlasts the write strobe. They also check the one-cycle done pulse, the idle latch strobe in split mode, and the frozen address during an access. Only the bench scenarios show that phase lengths match the programmed counts, including zero counts. The same holds for the latched address reaching the memory model and returning the right byte, and for stray requests during an access or its done cycle being dropped.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_AHOLD,
    ST_SETUP,
    ST_STROBE,
    ST_RECOV
  } xm_state_e;
endpackage

// File: rtl/xmem_phase_timer.sv
module xmem_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R11: a running count steps down by one each cycle
  assert_count_down_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_mux,
  input  logic [CNT_W-1:0]     cfg_ale_cyc,
  input  logic [CNT_W-1:0]     cfg_setup_cyc,
  input  logic [CNT_W-1:0]     cfg_strobe_cyc,
  input  logic                 req_start,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 tmr_expired,
  output logic                 tmr_load,
  output logic [CNT_W-1:0]     tmr_val,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_done,
  output logic [DATA_W-1:0]    ext_ad_out,
  output logic                 ext_ad_oe,
  input  logic [DATA_W-1:0]    ext_ad_in,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic [DATA_W-1:0]    ext_addr_lo,
  output logic                 ext_ale,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  xm_state_e state_q, nxt;
  logic              mux_q, wr_q;
  logic [DATA_W-1:0] alo_q, wdata_q;
  logic              accept, mux_n, wr_n_op, addr_phase;
  logic [DATA_W-1:0] alo_n, wdata_n;

  assign accept  = (state_q == ST_IDLE) && req_start;
  assign mux_n   = accept ? cfg_mux   : mux_q;
  assign wr_n_op = accept ? req_write : wr_q;
  assign alo_n   = accept ? req_addr[DATA_W-1:0] : alo_q;
  assign wdata_n = accept ? req_wdata : wdata_q;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = cfg_setup_cyc;
    case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (cfg_mux) begin
          nxt     = ST_ALE;
          tmr_val = cfg_ale_cyc;
        end else begin
          nxt     = ST_SETUP;
        end
      end
      ST_ALE:    if (tmr_expired) nxt = ST_AHOLD;
      ST_AHOLD: begin
        nxt      = ST_SETUP;
        tmr_load = 1'b1;
      end
      ST_SETUP: if (tmr_expired) begin
        nxt      = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = cfg_strobe_cyc;
      end
      ST_STROBE: if (tmr_expired) nxt = ST_RECOV;
      ST_RECOV:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign addr_phase = (nxt == ST_ALE) || (nxt == ST_AHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mux_q       <= 1'b0;
      wr_q        <= 1'b0;
      alo_q       <= '0;
      wdata_q     <= '0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      ext_ad_out  <= '0;
      ext_ad_oe   <= 1'b0;
      ext_addr_hi <= '0;
      ext_addr_lo <= '0;
      ext_ale     <= 1'b0;
      ext_rd_n    <= 1'b1;
      ext_wr_n    <= 1'b1;
    end else begin
      state_q    <= nxt;
      mux_q      <= mux_n;
      wr_q       <= wr_n_op;
      alo_q      <= alo_n;
      wdata_q    <= wdata_n;
      if (accept) begin
        ext_addr_hi <= req_addr[ADDR_W-1:DATA_W];
        ext_addr_lo <= cfg_mux ? '0 : req_addr[DATA_W-1:0];
      end
      ext_ale    <= (nxt == ST_ALE);
      ext_rd_n   <= !((nxt == ST_STROBE) && !wr_n_op);
      ext_wr_n   <= !((nxt == ST_STROBE) && wr_n_op);
      ext_ad_oe  <= addr_phase ||
                    (wr_n_op && (nxt == ST_SETUP || nxt == ST_STROBE || nxt == ST_RECOV));
      ext_ad_out <= addr_phase ? alo_n : wdata_n;
      rsp_done   <= (nxt == ST_RECOV);
      if (state_q == ST_STROBE && tmr_expired && !wr_q) rsp_rdata <= ext_ad_in;
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));
  assert_quiet_ale_R5: assert property (@(posedge clk) disable iff (rst)
    ext_ale |-> (ext_rd_n && ext_wr_n));
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ale) |-> (ext_ad_oe && $stable(ext_ad_out) && ext_rd_n && ext_wr_n));
  assert_rd_release_R4: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_ad_oe);
  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_wr_n) |-> (ext_ad_oe && $stable(ext_ad_out)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_nomux_ale_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && !mux_q) |-> !ext_ale);
  assert_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> ($stable(ext_addr_hi) && $stable(ext_addr_lo)));
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_mux,
  input  logic [CNT_W-1:0]         cfg_ale_cyc,
  input  logic [CNT_W-1:0]         cfg_setup_cyc,
  input  logic [CNT_W-1:0]         cfg_strobe_cyc,
  input  logic                     req_start,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        ext_ad_out,
  output logic                     ext_ad_oe,
  input  logic [DATA_W-1:0]        ext_ad_in,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic [DATA_W-1:0]        ext_addr_lo,
  output logic                     ext_ale,
  output logic                     ext_rd_n,
  output logic                     ext_wr_n
);
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  xmem_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  xmem_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_ale_cyc(cfg_ale_cyc),
    .cfg_setup_cyc(cfg_setup_cyc), .cfg_strobe_cyc(cfg_strobe_cyc),
    .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .tmr_expired(tmr_expired), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
    .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo), .ext_ale(ext_ale),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );
endmodule

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        mux;
    logic        wr;
    logic [7:0]  stray;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [3:0]  a;
    logic [3:0]  s;
    logic [3:0]  p;
  } vec_t;

  // stray: 0 none, 255 = inject during the done cycle, else cycle index
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 1'b1, 8'd0,   16'h12AB, 8'h3C, 4'd2, 4'd1, 4'd3},
    '{1'b1, 1'b0, 8'd0,   16'h34CD, 8'h00, 4'd1, 4'd2, 4'd2},
    '{1'b0, 1'b1, 8'd0,   16'h5678, 8'hA5, 4'd3, 4'd1, 4'd1},
    '{1'b0, 1'b0, 8'd0,   16'h9A01, 8'h00, 4'd1, 4'd3, 4'd2},
    '{1'b1, 1'b0, 8'd0,   16'hFF00, 8'h00, 4'd0, 4'd0, 4'd0},
    '{1'b1, 1'b1, 8'd2,   16'h0011, 8'h7E, 4'd1, 4'd1, 4'd1},
    '{1'b0, 1'b0, 8'd255, 16'h00FF, 8'h00, 4'd2, 4'd1, 4'd4},
    '{1'b1, 1'b0, 8'd0,   16'h8080, 8'h00, 4'd4, 4'd2, 4'd1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_mux = 1'b0;
  logic [3:0] cfg_ale_cyc = 4'd1, cfg_setup_cyc = 4'd1, cfg_strobe_cyc = 4'd1;
  logic req_start = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rsp_rdata, ext_ad_out, ext_ad_in, ext_addr_hi, ext_addr_lo;
  logic rsp_done, ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic cur_mux = 1'b0;
  logic [7:0] lat_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  // external transparent latch and SRAM read model
  always_latch if (ext_ale) lat_q <= ext_ad_out;
  assign ext_ad_in = !ext_rd_n ? ((cur_mux ? lat_q : ext_addr_lo) ^ ext_addr_hi ^ 8'h5A)
                               : 8'hEE;

  xmem_bus_ctrl u_xmem_bus_ctrl (
    .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_ale_cyc(cfg_ale_cyc),
    .cfg_setup_cyc(cfg_setup_cyc), .cfg_strobe_cyc(cfg_strobe_cyc),
    .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
    .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo), .ext_ale(ext_ale),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nz(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  task automatic check_idle(input string tag);
    chk(ext_ale == 1'b0, tag, ext_ale, 0);
    chk(ext_rd_n && ext_wr_n, tag, {ext_rd_n, ext_wr_n}, 3);
    chk(ext_ad_oe == 1'b0, tag, ext_ad_oe, 0);
    chk(rsp_done == 1'b0, tag, rsp_done, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] prev_rd;
    prev_rd = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check_idle("R12 reset idle");
    chk(rsp_rdata == 8'h00, "R12 reset rdata", rsp_rdata, 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int aN, sN, pN, base, rec, sk;
      bit in_st, in_su, wdrv;
      v = TBL[i];
      aN = nz(v.a); sN = nz(v.s); pN = nz(v.p);
      base = v.mux ? aN + 1 : 0;
      rec  = base + sN + pN + 1;
      sk   = (v.stray == 8'd255) ? rec : int'(v.stray);
      cur_mux        = v.mux;
      cfg_mux        = v.mux;
      cfg_ale_cyc    = v.a;
      cfg_setup_cyc  = v.s;
      cfg_strobe_cyc = v.p;
      req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
      req_start = 1'b1;
      for (int k = 1; k <= rec + 2; k++) begin
        @(negedge clk);
        req_start = 1'b0;
        if (k > rec) begin
          check_idle((v.stray != 0) ? "R10 stray dropped" : "R8 back to idle");
        end else begin
          in_su = (k > base) && (k <= base + sN);
          in_st = (k > base + sN) && (k <= base + sN + pN);
          wdrv  = v.wr && (k > base);
          // R1 R2 R9 R11: latch strobe window
          chk(ext_ale == (v.mux && k <= aN),
              v.mux ? ((v.a == 0) ? "R11 ale len" : "R1 R2 ale len") : "R1 R9 ale idle",
              ext_ale, v.mux && k <= aN);
          chk(ext_addr_hi == v.addr[15:8], "R2 addr hi", ext_addr_hi, v.addr[15:8]);
          chk(ext_addr_lo == (v.mux ? 8'h00 : v.addr[7:0]), "R9 addr lo",
              ext_addr_lo, v.mux ? 8'h00 : v.addr[7:0]);
          chk(ext_rd_n == !(in_st && !v.wr),
              (v.s == 0 || v.p == 0) ? "R11 rd strobe" : "R5 rd strobe",
              ext_rd_n, !(in_st && !v.wr));
          chk(ext_wr_n == !(in_st && v.wr), "R5 wr strobe", ext_wr_n, !(in_st && v.wr));
          if (v.mux && k <= aN + 1) begin
            chk(ext_ad_oe && ext_ad_out == v.addr[7:0],
                (k == aN + 1) ? "R3 addr hold" : "R2 addr on AD",
                {ext_ad_oe, ext_ad_out}, {1'b1, v.addr[7:0]});
          end else begin
            chk(ext_ad_oe == wdrv, in_su ? "R4 setup drive" : "R6 data drive",
                ext_ad_oe, wdrv);
            if (wdrv)
              chk(ext_ad_out == v.wdata, "R4 R6 write data", ext_ad_out, v.wdata);
          end
          chk(rsp_done == (k == rec), "R8 done pulse", rsp_done, k == rec);
          if (k == rec) begin
            logic [7:0] exp_rd;
            exp_rd = v.wr ? prev_rd : (v.addr[7:0] ^ v.addr[15:8] ^ 8'h5A);
            chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
            prev_rd = exp_rd;
          end
        end
        if (k == sk) begin
          // R10: conflicting request while busy
          req_start = 1'b1;
          req_write = ~v.wr;
          req_addr  = ~v.addr;
          req_wdata = 8'hC3;
          cfg_mux   = ~v.mux;
        end
      end
    end

    finished = 1'b1;
    summary();
  end
endmodule